// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block drives the multi-cycle sequences behind two control-flow instructions of a 32-bit CPU with 16-bit instructions. On a software trap it saves the status word and the resume address on the stack, using R15 as the stack pointer. It then fetches the new program counter from a vector table. The table entry is found by adding four times the trap's 8-bit immediate to the vector base. On return from exception it pops the program counter and the status word, restores R15, and lets one delay-slot instruction run before the popped program counter is written.

The CPU presents the decoded instruction with `insn_valid` and supplies its current PC, SR, VBR and R15. The sequencer owns a single 32-bit memory port. Each transfer completes on a clock edge where `mem_req` and `mem_ready` are both high. Results go back through write strobes for PC, SR and R15.

States: `S_IDLE` (accept), `S_PUSH_SR`, `S_PUSH_PC`, `S_VEC_RD`, `S_VEC_WB`, `S_FILL` (trap path); `S_POP_PC`, `S_POP_SR`, `S_SLOT`, `S_BRANCH` (return path). Transitions:
- `S_IDLE` goes to `S_PUSH_SR` on a trap, or to `S_POP_PC` on a return.
- Each memory state advances on `mem_ready`.
- `S_VEC_WB` always goes to `S_FILL`.
- `S_FILL` goes back to `S_IDLE` after its fixed count.
- `S_SLOT` goes to `S_BRANCH` when the slot instruction is presented.
- `S_BRANCH` always goes to `S_IDLE`.

Top module: `trap_seq`

## Requirements
- R1: In idle with `insn_valid` high, an instruction whose upper byte is 0xC3 starts a trap and the code 0x002B starts a return; any other code is ignored: `busy` and `mem_req` stay low.
- R2: A trap writes SR to address R15-4 first, then writes the address of the next instruction (trap PC + 2) to R15-8.
- R3: A trap reads the word at VBR + 4 × imm, where imm is bits 7:0 zero-extended. It then pulses `pc_we` once with that word, together with `r15_we` carrying R15-8.
- R4: With `mem_ready` held high, `busy` stays high for exactly 7 cycles after the issuing edge, so a trap occupies 8 cycles.
- R5: A return reads PC from address R15, then reads SR from R15+4. When the SR read completes, `sr_we` carries the popped SR and `r15_we` carries R15+8 in the same cycle.
- R6: After the pops, `slot_o` stays high until one slot instruction is presented. `pc_we` with the popped PC follows in the next cycle, so a return takes at least 5 cycles.
- R7: A trap or return code presented as the slot instruction raises `illegal_slot` for one cycle, in the same cycle as the branch `pc_we`. It starts no new sequence.
- R8: While `mem_ready` is low, address, data and direction of the pending transfer are held. Each wait cycle lengthens the sequence by one cycle without changing its results.
- R9: `busy` is high from the edge after issue until the sequence ends. `mem_req` is never high while `busy` is low.
- R10: After reset `busy`, `mem_req`, `pc_we`, `sr_we`, `r15_we`, `slot_o` and `illegal_slot` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction presented this cycle |
| insn | input | 16 | Instruction code |
| pc_i | input | 32 | Address of the presented instruction |
| sr_i | input | 32 | Current status register |
| vbr_i | input | 32 | Vector base |
| r15_i | input | 32 | Current stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes this edge |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | New program counter |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 32 | New status register |
| r15_we | output | 1 | Stack pointer write strobe |
| r15_wdata | output | 32 | New stack pointer |
| busy | output | 1 | Sequence in progress |
| slot_o | output | 1 | Waiting for the delay-slot instruction |
| illegal_slot | output | 1 | Trap or return found in the delay slot |

## Verification
The return's final branch and the illegal-slot detection land in the same cycle. Presenting a trap code as the slot instruction makes `illegal_slot` and the branch `pc_we` rise together. The bench requires both to be seen in one sampled cycle and the restored PC to still be correct. It also requires that no trap push follows afterwards. A second coincidence is the SR restore and the R15 restore, which both fire on the edge the SR read completes. This is judged under inserted wait states to show that neither strobe fires early.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [7:0]  OPC_TRAP_HI = 8'hC3;
    localparam logic [15:0] OPC_RETURN  = 16'h002B;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_SR,
        S_PUSH_PC,
        S_VEC_RD,
        S_VEC_WB,
        S_FILL,
        S_POP_PC,
        S_POP_SR,
        S_SLOT,
        S_BRANCH
    } seq_state_e;

endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_pkg::*;
(
    input  logic [15:0] insn,
    output logic        is_trap,
    output logic        is_ret,
    output logic [7:0]  imm
);
    assign is_trap = (insn[15:8] == OPC_TRAP_HI);
    assign is_ret  = (insn == OPC_RETURN);
    assign imm     = insn[7:0];
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [7:0]      imm,
    output logic [XLEN-1:0] addr
);
    localparam int PADW = XLEN - 10;
    assign addr = base + {{PADW{1'b0}}, imm, 2'b00};
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int TRAP_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [15:0]     insn,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] vbr_i,
    input  logic [XLEN-1:0] r15_i,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_wdata,
    output logic            sr_we,
    output logic [XLEN-1:0] sr_wdata,
    output logic            r15_we,
    output logic [XLEN-1:0] r15_wdata,
    output logic            busy,
    output logic            slot_o,
    output logic            illegal_slot
);
    // Cycles spent before the fill stretch: issue, two pushes, vector read, write-back.
    localparam int              FILL_N = TRAP_CYC - 5;
    localparam int              FW     = (FILL_N > 1) ? $clog2(FILL_N) : 1;
    localparam logic [FW-1:0]   FILL_LAST = FW'(FILL_N - 1);
    localparam logic [XLEN-1:0] WORD   = XLEN'(4);
    localparam logic [XLEN-1:0] PAIR   = XLEN'(8);
    localparam logic [XLEN-1:0] ISTEP  = XLEN'(2);

    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] sp_q, pc_q, sr_q, vec_q;
    logic [FW-1:0]   fill_q;
    logic            ill_q;

    logic            dec_trap, dec_ret;
    logic [7:0]      dec_imm;
    logic [XLEN-1:0] vec_addr;

    trap_decode u_dec (
        .insn    (insn),
        .is_trap (dec_trap),
        .is_ret  (dec_ret),
        .imm     (dec_imm)
    );

    trap_vec #(.XLEN(XLEN)) u_vec (
        .base (vbr_i),
        .imm  (dec_imm),
        .addr (vec_addr)
    );

    // State register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sp_q    <= '0;
            pc_q    <= '0;
            sr_q    <= '0;
            vec_q   <= '0;
            fill_q  <= '0;
            ill_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    ill_q  <= 1'b0;
                    fill_q <= '0;
                    if (insn_valid && (dec_trap || dec_ret)) begin
                        sp_q  <= r15_i;
                        pc_q  <= pc_i + ISTEP;
                        sr_q  <= sr_i;
                        vec_q <= vec_addr;
                    end
                end
                S_VEC_RD, S_POP_PC: if (mem_ready) pc_q <= mem_rdata;
                S_FILL:             fill_q <= fill_q + 1'b1;
                S_SLOT:             if (insn_valid) ill_q <= dec_trap || dec_ret;
                default: ;
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        state_d      = state_q;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        pc_we        = 1'b0;
        pc_wdata     = pc_q;
        sr_we        = 1'b0;
        sr_wdata     = mem_rdata;
        r15_we       = 1'b0;
        r15_wdata    = '0;
        busy         = (state_q != S_IDLE);
        slot_o       = 1'b0;
        illegal_slot = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (insn_valid && dec_trap)     state_d = S_PUSH_SR;
                else if (insn_valid && dec_ret) state_d = S_POP_PC;
            end
            S_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - WORD;
                mem_wdata = sr_q;
                if (mem_ready) state_d = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - PAIR;
                mem_wdata = pc_q;
                if (mem_ready) state_d = S_VEC_RD;
            end
            S_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_q;
                if (mem_ready) state_d = S_VEC_WB;
            end
            S_VEC_WB: begin
                pc_we     = 1'b1;
                r15_we    = 1'b1;
                r15_wdata = sp_q - PAIR;
                state_d   = S_FILL;
            end
            S_FILL: begin
                if (fill_q == FILL_LAST) state_d = S_IDLE;
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp_q;
                if (mem_ready) state_d = S_POP_SR;
            end
            S_POP_SR: begin
                mem_req   = 1'b1;
                mem_addr  = sp_q + WORD;
                sr_we     = mem_ready;
                r15_we    = mem_ready;
                r15_wdata = sp_q + PAIR;
                if (mem_ready) state_d = S_SLOT;
            end
            S_SLOT: begin
                slot_o = 1'b1;
                if (insn_valid) state_d = S_BRANCH;
            end
            S_BRANCH: begin
                pc_we        = 1'b1;
                illegal_slot = ill_q;
                state_d      = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8
    AST_SR_WITH_R15: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (r15_we && r15_wdata == mem_addr + WORD)); // R5
    AST_SLOT_THEN_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o && insn_valid) |=> (pc_we && !slot_o)); // R6
    AST_ILLEGAL_AT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |-> (pc_we && !mem_req)); // R7
    AST_PC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !pc_we); // R3
    AST_IDLE_AFTER_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !r15_we) |=> !busy); // R7

endmodule

// File: tb/trap_seq_bench.sv
module trap_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] pc_i = '0, sr_i = '0, vbr_i = '0, r15_i = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        pc_we, sr_we, r15_we, busy, slot_o, illegal_slot;
    logic [31:0] pc_wdata, sr_wdata, r15_wdata;

    logic [31:0] mem [0:511];
    assign mem_rdata = mem[mem_addr[10:2]];

    always #10 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .pc_i(pc_i), .sr_i(sr_i), .vbr_i(vbr_i), .r15_i(r15_i),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .r15_we(r15_we), .r15_wdata(r15_wdata), .busy(busy), .slot_o(slot_o),
        .illegal_slot(illegal_slot)
    );

    int checks = 0;
    int errors = 0;

    // Observations of one sequence
    int          n_busy, n_pc, n_sr, n_r15, n_ill, n_wr, n_coinc;
    logic [31:0] pc_last, sr_last, r15_last, sr_r15;
    logic [31:0] wr_addr [0:3];
    logic [31:0] wr_data [0:3];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_busy = 0; n_pc = 0; n_sr = 0; n_r15 = 0; n_ill = 0; n_wr = 0; n_coinc = 0;
        pc_last = '0; sr_last = '0; r15_last = '0; sr_r15 = '0;
    endtask

    // Issue one instruction, then step until busy drops
    task automatic run_seq(input logic [15:0] code, input logic [15:0] slot_code,
                           input int slot_delay, input bit stall);
        int  sw = 0;
        bit  waited = 1'b0;
        clear_obs();
        @(negedge clk);
        insn = code; insn_valid = 1'b1; mem_ready = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            insn_valid = 1'b0;
            if (stall && mem_req && !waited) begin mem_ready = 1'b0; waited = 1'b1; end
            else begin mem_ready = 1'b1; if (mem_req) waited = 1'b0; end
            if (slot_o) begin
                if (sw == slot_delay) begin insn = slot_code; insn_valid = 1'b1; end
                sw++;
            end
            #1;
            if (mem_req && !busy) begin
                errors++; $display("FAIL R9 mem_req without busy actual=1 expected=0");
            end
            if (!busy) break;
            n_busy++;
            if (pc_we) begin n_pc++; pc_last = pc_wdata; if (illegal_slot) n_coinc++; end
            if (sr_we) begin n_sr++; sr_last = sr_wdata; sr_r15 = r15_we ? r15_wdata : 32'hDEAD; end
            if (r15_we) begin n_r15++; r15_last = r15_wdata; end
            if (illegal_slot) n_ill++;
            if (mem_req && mem_we && mem_ready) begin
                if (n_wr < 4) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
                mem[mem_addr[10:2]] = mem_wdata;
                n_wr++;
            end
        end
        insn_valid = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        check("R10", "busy", {31'd0, busy}, 32'd0);
        check("R10", "mem_req", {31'd0, mem_req}, 32'd0);
        check("R10", "strobes", {29'd0, pc_we, sr_we, r15_we}, 32'd0);
        check("R10", "slot/illegal", {30'd0, slot_o, illegal_slot}, 32'd0);
    endtask

    task automatic test_trap(input logic [7:0] imm, input bit stall, input int exp_busy, input string tag);
        logic [31:0] vaddr;
        pc_i = 32'h0000_1000; sr_i = 32'h0000_00F0; vbr_i = 32'h0000_0200; r15_i = 32'h0000_0100;
        vaddr = vbr_i + {22'd0, imm, 2'b00};
        mem[vaddr[10:2]] = 32'hABC0_0000 | {24'd0, imm};
        run_seq({8'hC3, imm}, 16'h0009, 0, stall);
        check("R2", {tag, " write count"}, n_wr, 32'd2);
        check("R2", {tag, " first write addr"}, wr_addr[0], 32'h0000_00FC);
        check("R2", {tag, " first write SR"}, wr_data[0], 32'h0000_00F0);
        check("R2", {tag, " second write addr"}, wr_addr[1], 32'h0000_00F8);
        check("R2", {tag, " saved PC"}, wr_data[1], 32'h0000_1002);
        check("R3", {tag, " new PC"}, pc_last, 32'hABC0_0000 | {24'd0, imm});
        check("R3", {tag, " pc_we count"}, n_pc, 32'd1);
        check("R3", {tag, " R15"}, r15_last, 32'h0000_00F8);
        check(stall ? "R8" : "R4", {tag, " busy cycles"}, n_busy, exp_busy);
    endtask

    task automatic test_return(input logic [15:0] slot_code, input int delay, input bit stall,
                               input int exp_busy, input int exp_ill, input string tag);
        r15_i = 32'h0000_0180;
        mem[32'h180 >> 2] = 32'h0000_4444;
        mem[32'h184 >> 2] = 32'h0000_0033;
        run_seq(16'h002B, slot_code, delay, stall);
        check("R5", {tag, " SR restored"}, sr_last, 32'h0000_0033);
        check("R5", {tag, " R15 with SR"}, sr_r15, 32'h0000_0188);
        check("R5", {tag, " no writes"}, n_wr, 32'd0);
        check("R6", {tag, " branch PC"}, pc_last, 32'h0000_4444);
        check("R6", {tag, " pc_we count"}, n_pc, 32'd1);
        check(stall ? "R8" : "R6", {tag, " busy cycles"}, n_busy, exp_busy);
        check("R7", {tag, " illegal with branch"}, n_coinc, exp_ill);
        check("R7", {tag, " illegal count"}, n_ill, exp_ill);
    endtask

    task automatic test_ignore();
        int seen = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            insn = (k == 0) ? 16'h0009 : (k == 1) ? 16'hC2FF : (k == 2) ? 16'h002A : 16'h102B;
            insn_valid = 1'b1;
            #1;
            if (busy || mem_req) seen++;
        end
        @(negedge clk);
        insn_valid = 1'b0;
        #1;
        if (busy || mem_req) seen++;
        check("R1", "other codes ignored", seen, 32'd0);
    endtask

    task automatic test_quiet_after(input string tag);
        int act = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            if (busy || mem_req) act++;
        end
        check("R7", {tag, " no sequence from slot code"}, act, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        mem_ready = 1'b1;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_ignore();
        test_trap(8'h05, 1'b0, 7, "trap imm05");
        test_trap(8'hFF, 1'b0, 7, "trap immFF");
        test_trap(8'h00, 1'b1, 10, "trap stalled");
        test_return(16'h0009, 0, 1'b0, 4, 0, "return");
        test_return(16'h0009, 3, 1'b0, 7, 0, "return late slot");
        test_return(16'h0009, 0, 1'b1, 6, 0, "return stalled");
        test_return(16'hC301, 0, 1'b0, 4, 1, "return slot trap");
        test_quiet_after("slot trap");
        test_return(16'h002B, 1, 1'b0, 5, 1, "return slot return");
        test_quiet_after("slot return");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule